// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind the slave command engine of a serial EEPROM and turns a write command into one commit to the storage array. The command engine announces a new write command with a start address. It then delivers each received data byte with a strobe. It also reports how many data bits of the next byte have arrived so far, and it signals when a STOP has been seen. The controller loads the bytes into a page latch. The latch address steps only through the low offset bits of the address, so the page bits stay frozen and the offset wraps around inside the page. When a STOP closes a command that holds at least one complete byte, the block raises busy. It holds busy for a programmable number of clock cycles, standing in for the internal write time, and commits the whole page in one array write at the end.

Write protection and a low-supply indicator can keep the array from being rewritten. The write-protect input is ignored until the first data byte is taken. From that moment until the write cycle ends, a high write-protect either drops the command or cuts the write cycle short. On a forced end, the loaded page locations are filled with all-ones to model undefined contents, and busy drops at the next clock edge. While busy, every new command, byte or STOP is ignored.

Top module: `eeprom_page_writer`

## Requirements
- R1: During and right after reset, busy is low and the array write strobe is low.
- R2: Each accepted byte goes to the current latch offset. The offset starts at the command address bits [4:0] and steps by one modulo 32. The page number sent with the commit equals the command address bits [11:5] and never changes during the command. A start at offset 1Eh fills 1Eh, 1Fh, 00h, 01h.
- R3: When more than 32 bytes are sent, a later byte replaces the earlier byte at the same wrapped offset, and the commit carries the later value.
- R4: A STOP that arrives with bit_count = 0, after at least one accepted byte, starts a write cycle. Busy is high for exactly WRITE_CYCLES clock cycles. In the last busy cycle, arr_we pulses once. The pulse carries the latched bytes, and arr_mask has bit i set for each offset i that was loaded.
- R5: A STOP with bit_count not equal to 0 (partial byte), or a STOP with no byte accepted, discards the command. Busy stays low and the array is not written.
- R6: If low_vdd is high when the STOP arrives, the command is discarded and busy stays low.
- R7: A high wp that is seen only before the first data byte of a command has no effect, and the write proceeds normally.
- R8: If wp is high in the cycle of the first byte strobe, or in any later cycle before the STOP, the command is discarded and no write cycle starts.
- R9: If wp is high in any busy cycle, arr_we pulses in that same cycle with all data bits set to 1 over the loaded mask. Busy is low from the next cycle on.
- R10: If wp rises in the final busy cycle, the forced end wins over the normal commit, and the data is all ones.
- R11: Command start, byte strobes and STOP received while busy are ignored. Busy length, page, mask and data of the running write are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: new write command, address valid |
| cmd_addr | input | 12 | Start address of the command |
| byte_valid | input | 1 | Pulse: one complete data byte received (D0 edge) |
| byte_data | input | 8 | Data byte qualified by byte_valid |
| bit_count | input | 4 | Data bits of the next byte received since the last byte strobe |
| stop_strobe | input | 1 | Pulse: STOP condition detected |
| wp | input | 1 | Write protect, active high |
| low_vdd | input | 1 | Supply-low indicator, active high |
| busy | output | 1 | Internal write cycle in progress |
| arr_we | output | 1 | Array page write strobe |
| arr_page | output | 7 | Page number of the array write |
| arr_mask | output | 32 | Per-offset byte enables of the array write |
| arr_data | output | 256 | Page data, byte i at bits [8i+7:8i] |

## Verification
Two events can fall on the same clock edge: the write timer expiring, and the forced end from write protect. The bench provokes this by raising wp in exactly the last busy cycle, which it finds by counting busy cycles from the STOP. It then requires a single commit pulse in that cycle with all-ones data and busy low one cycle later. A second overlap is also tested: a command start, a byte and a STOP are all injected into the same busy cycle. The bench then requires that the running write completes with its original length, page and data.

// File: rtl/epw_pkg.sv
package epw_pkg;

  localparam int EPW_ADDR_W     = 12;
  localparam int EPW_PAGE_BYTES = 32;
  localparam int EPW_DATA_W     = 8;

  typedef enum logic [1:0] {
    EPW_IDLE    = 2'd0,
    EPW_COLLECT = 2'd1,
    EPW_PROG    = 2'd2
  } epw_state_t;

endpackage

// File: rtl/epw_offset_seq.sv
module epw_offset_seq #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [ADDR_W-1:0]     start_addr,
  input  logic                  step,
  output logic [OFF_W-1:0]      cur_off,
  output logic [PAGE_W-1:0]     page,
  output logic [PAGE_BYTES-1:0] loaded,
  output logic                  any_loaded
);

  // offset advance inside one page: the page bits are never touched
  function automatic logic [OFF_W-1:0] bump_off(input logic [OFF_W-1:0] off);
    if (off == OFF_W'(PAGE_BYTES - 1)) return '0;
    return off + OFF_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_off <= '0;
      page    <= '0;
    end else if (load) begin
      cur_off <= start_addr[OFF_W-1:0];
      page    <= start_addr[ADDR_W-1:OFF_W];
    end else if (step) begin
      cur_off <= bump_off(cur_off);
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 loaded[i] <= 1'b0;
      else if (load)                              loaded[i] <= 1'b0;
      else if (step && cur_off == OFF_W'(i))      loaded[i] <= 1'b1;
    end
  end

  assign any_loaded = |loaded;

endmodule

// File: rtl/epw_page_latch.sv
module epw_page_latch #(
  parameter int PAGE_BYTES = 32,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [OFF_W-1:0]             wr_off,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [PAGE_BYTES*DATA_W-1:0] page_flat
);

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot <= '1;
      else if (wr && wr_off == OFF_W'(i))  slot <= wr_data;
    end
    assign page_flat[i*DATA_W +: DATA_W] = slot;
  end

endmodule

// File: rtl/epw_wtimer.sv
module epw_wtimer #(
  parameter int WRITE_CYCLES = 1000,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (load)              cnt <= CNT_W'(WRITE_CYCLES - 1);
    else if (run && cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign done = run && (cnt == '0);

endmodule

// File: rtl/epw_ctrl.sv
module epw_ctrl
  import epw_pkg::*;
#(
  parameter int BITCNT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_start,
  input  logic                byte_valid,
  input  logic [BITCNT_W-1:0] bit_count,
  input  logic                stop_strobe,
  input  logic                wp,
  input  logic                low_vdd,
  input  logic                any_loaded,
  input  logic                timer_done,
  output logic                seq_load,
  output logic                accept_byte,
  output logic                timer_load,
  output logic                window_open,
  output logic                collect_kill,
  output logic                commit_ok,
  output logic                commit_kill,
  output logic                busy
);

  epw_state_t state, state_nx;

  logic in_collect, in_prog, has_byte;

  // STOP qualifies only on a byte boundary with data present and supply good
  function automatic logic stop_commits(input logic stop, input logic [BITCNT_W-1:0] bits,
                                        input logic data_seen, input logic supply_low);
    return stop && (bits == '0) && data_seen && !supply_low;
  endfunction

  assign in_collect   = (state == EPW_COLLECT);
  assign in_prog      = (state == EPW_PROG);
  assign has_byte     = any_loaded || byte_valid;

  assign seq_load     = cmd_start && !in_prog;
  assign accept_byte  = in_collect && byte_valid && !cmd_start;
  assign window_open  = in_collect && has_byte;
  assign collect_kill = in_collect && !cmd_start && window_open && wp;
  assign timer_load   = in_collect && !cmd_start && !collect_kill &&
                        stop_commits(stop_strobe, bit_count, has_byte, low_vdd);
  assign commit_kill  = in_prog && wp;
  assign commit_ok    = in_prog && !wp && timer_done;
  assign busy         = in_prog;

  always_comb begin
    state_nx = state;
    unique case (state)
      EPW_IDLE:    if (cmd_start) state_nx = EPW_COLLECT;
      EPW_COLLECT: begin
        if (cmd_start)         state_nx = EPW_COLLECT;
        else if (collect_kill) state_nx = EPW_IDLE;
        else if (timer_load)   state_nx = EPW_PROG;
        else if (stop_strobe)  state_nx = EPW_IDLE;
      end
      EPW_PROG:    if (commit_kill || commit_ok) state_nx = EPW_IDLE;
      default:     state_nx = EPW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= EPW_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int ADDR_W       = EPW_ADDR_W,
  parameter int PAGE_BYTES   = EPW_PAGE_BYTES,
  parameter int DATA_W       = EPW_DATA_W,
  parameter int WRITE_CYCLES = 1000,
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int PAGE_W      = ADDR_W - OFF_W,
  localparam int BITCNT_W    = $clog2(DATA_W + 1),
  localparam int FLAT_W      = PAGE_BYTES * DATA_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_start,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic                  byte_valid,
  input  logic [DATA_W-1:0]     byte_data,
  input  logic [BITCNT_W-1:0]   bit_count,
  input  logic                  stop_strobe,
  input  logic                  wp,
  input  logic                  low_vdd,
  output logic                  busy,
  output logic                  arr_we,
  output logic [PAGE_W-1:0]     arr_page,
  output logic [PAGE_BYTES-1:0] arr_mask,
  output logic [FLAT_W-1:0]     arr_data
);

  logic              seq_load, accept_byte, timer_load, timer_done;
  logic              window_open, collect_kill, commit_ok, commit_kill;
  logic              any_loaded;
  logic [OFF_W-1:0]  cur_off;
  logic [FLAT_W-1:0] latch_flat;

  // undefined-contents stand-in used on a forced end
  function automatic logic [FLAT_W-1:0] poison_page();
    return {FLAT_W{1'b1}};
  endfunction

  epw_ctrl #(.BITCNT_W(BITCNT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_start    (cmd_start),
    .byte_valid   (byte_valid),
    .bit_count    (bit_count),
    .stop_strobe  (stop_strobe),
    .wp           (wp),
    .low_vdd      (low_vdd),
    .any_loaded   (any_loaded),
    .timer_done   (timer_done),
    .seq_load     (seq_load),
    .accept_byte  (accept_byte),
    .timer_load   (timer_load),
    .window_open  (window_open),
    .collect_kill (collect_kill),
    .commit_ok    (commit_ok),
    .commit_kill  (commit_kill),
    .busy         (busy)
  );

  epw_offset_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (seq_load),
    .start_addr (cmd_addr),
    .step       (accept_byte),
    .cur_off    (cur_off),
    .page       (arr_page),
    .loaded     (arr_mask),
    .any_loaded (any_loaded)
  );

  epw_page_latch #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (accept_byte),
    .wr_off    (cur_off),
    .wr_data   (byte_data),
    .page_flat (latch_flat)
  );

  epw_wtimer #(.WRITE_CYCLES(WRITE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (timer_load),
    .run   (busy),
    .done  (timer_done)
  );

  assign arr_we   = commit_ok || commit_kill;
  assign arr_data = commit_kill ? poison_page() : latch_flat;

endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
  parameter int WRITE_CYCLES = 1000,
  parameter int FLAT_W       = 256,
  parameter int BITCNT_W     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                arr_we,
  input logic [FLAT_W-1:0]   arr_data,
  input logic                wp,
  input logic                low_vdd,
  input logic                stop_strobe,
  input logic [BITCNT_W-1:0] bit_count,
  input logic                collect_kill,
  input logic                timer_load
);

  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  // R1: reset state
  always @(posedge clk) if (!rst_n) a_r1_quiet_in_reset: assert (!busy && !arr_we);

  // R4: the array is written only inside a write cycle
  a_r4_we_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R4: a write cycle begins only after a STOP
  a_r4_busy_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_strobe));

  // R4: an undisturbed write cycle lasts exactly WRITE_CYCLES
  a_r4_cycle_length: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && !$past(wp)) |-> (run_len == WRITE_CYCLES));

  // R5: partial byte at STOP never starts a write
  a_r5_partial_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && !busy && bit_count != '0) |=> !busy);

  // R6: supply low at STOP never starts a write
  a_r6_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_strobe && !busy && low_vdd) |=> !busy);

  // R8: a collection killed by wp does not start a timer in the same cycle
  a_r8_kill_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    collect_kill |-> !timer_load);

  // R9 / R10: wp in a busy cycle forces an all-ones commit now
  a_r9_forced_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp) |-> (arr_we && arr_data == {FLAT_W{1'b1}}));

  // R9: busy ends right after any commit pulse
  a_r9_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> !busy);

endmodule

bind eeprom_page_writer epw_checker #(
  .WRITE_CYCLES (WRITE_CYCLES),
  .FLAT_W       (FLAT_W),
  .BITCNT_W     (BITCNT_W)
) u_epw_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .arr_we       (arr_we),
  .arr_data     (arr_data),
  .wp           (wp),
  .low_vdd      (low_vdd),
  .stop_strobe  (stop_strobe),
  .bit_count    (bit_count),
  .collect_kill (collect_kill),
  .timer_load   (timer_load)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

  localparam int W = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_start = 1'b0;
  logic [11:0]  cmd_addr = '0;
  logic         byte_valid = 1'b0;
  logic [7:0]   byte_data = '0;
  logic [3:0]   bit_count = '0;
  logic         stop_strobe = 1'b0;
  logic         wp = 1'b0;
  logic         low_vdd = 1'b0;
  logic         busy, arr_we;
  logic [6:0]   arr_page;
  logic [31:0]  arr_mask;
  logic [255:0] arr_data;

  eeprom_page_writer #(.WRITE_CYCLES(W)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .bit_count(bit_count),
    .stop_strobe(stop_strobe), .wp(wp), .low_vdd(low_vdd), .busy(busy),
    .arr_we(arr_we), .arr_page(arr_page), .arr_mask(arr_mask), .arr_data(arr_data)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // reference model of one command
  logic [7:0]  m_data [32];
  logic [31:0] m_mask;
  logic [6:0]  m_page;
  int          m_off;

  // results of one write cycle
  int           r_busy_len, r_we_cnt, r_we_idx;
  logic [6:0]   r_page;
  logic [31:0]  r_mask;
  logic [255:0] r_data;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int wrap_next(input int off);
    return (off + 1) % 32;
  endfunction

  task automatic send_cmd(input logic [11:0] addr);
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = addr;
    m_page = addr / 32; m_off = addr % 32; m_mask = '0;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int b = 1; b < 8; b++) begin
      bit_count = 4'(b);
      @(negedge clk);
    end
    bit_count = '0; byte_valid = 1'b1; byte_data = d;
    m_data[m_off] = d; m_mask[m_off] = 1'b1; m_off = wrap_next(m_off);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic send_stop(input logic [3:0] bits);
    bit_count = bits; stop_strobe = 1'b1;
    @(negedge clk);
    stop_strobe = 1'b0; bit_count = '0;
  endtask

  // follows busy from the current negedge; wp_at = busy cycle that raises wp
  task automatic run_prog(input int wp_at, input bit disturb);
    r_busy_len = 0; r_we_cnt = 0; r_we_idx = 0;
    for (int k = 0; k < W + 20; k++) begin
      if (k > 0) @(negedge clk);
      if (r_busy_len == 4) begin
        cmd_start = 1'b0; byte_valid = 1'b0; stop_strobe = 1'b0;
      end
      if (!busy) break;
      r_busy_len++;
      if (r_busy_len == wp_at) wp = 1'b1;
      if (disturb && r_busy_len == 3) begin
        cmd_start = 1'b1; cmd_addr = 12'h7A5; byte_valid = 1'b1;
        byte_data = 8'h5C; stop_strobe = 1'b1;
      end
      #1;
      if (arr_we) begin
        r_we_cnt++; r_we_idx = r_busy_len;
        r_page = arr_page; r_mask = arr_mask; r_data = arr_data;
      end
    end
    wp = 1'b0;
  endtask

  task automatic judge(input string tag, input bit forced, input int exp_len);
    bit same;
    chk(r_busy_len == exp_len, {tag, " busy length"}, 64'(r_busy_len), 64'(exp_len));
    chk(r_we_cnt == 1 && r_we_idx == exp_len, {tag, " commit cycle"}, 64'(r_we_idx), 64'(exp_len));
    chk(r_page == m_page, {tag, " page"}, 64'(r_page), 64'(m_page));
    chk(r_mask == m_mask, {tag, " mask"}, 64'(r_mask), 64'(m_mask));
    same = 1'b1;
    for (int i = 0; i < 32; i++)
      if (m_mask[i] && r_data[i*8 +: 8] != (forced ? 8'hFF : m_data[i])) same = 1'b0;
    chk(same, {tag, " data"}, 64'(r_data[63:0]), forced ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0);
  endtask

  task automatic expect_idle(input string tag);
    #1;
    chk(!busy && !arr_we, {tag, " no write"}, 64'(busy), 64'h0);
    @(negedge clk); #1;
    chk(!busy, {tag, " still idle"}, 64'(busy), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R4 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !arr_we, "R1 in reset", 64'(busy), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !arr_we, "R1 after reset", 64'(busy), 64'h0);

    // R2: wrap from offset 1Eh, page bits frozen
    send_cmd(12'h3DE);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    send_stop(4'd0);
    run_prog(0, 1'b0);
    judge("R2 wrap", 1'b0, W);
    chk(r_mask == 32'hC000_0003, "R2 wrap offsets", 64'(r_mask), 64'hC000_0003);
    chk(r_data[8*31 +: 8] == 8'h22 && r_data[7:0] == 8'h33, "R2 wrap order",
        64'(r_data[7:0]), 64'h33);

    // R3: 34 bytes from offset 5 overwrite offsets 5 and 6
    send_cmd(12'h0A5);
    for (int i = 0; i < 34; i++) send_byte(8'(i + 8'h40));
    send_stop(4'd0);
    run_prog(0, 1'b0);
    judge("R3 overwrite", 1'b0, W);
    chk(r_data[8*5 +: 8] == 8'h60, "R3 later byte wins", 64'(r_data[8*5 +: 8]), 64'h60);

    // R4: random commands
    for (int t = 0; t < 6; t++) begin
      int len;
      len = 1 + int'($urandom % 40);
      send_cmd(12'($urandom));
      for (int i = 0; i < len; i++) send_byte(8'($urandom));
      send_stop(4'd0);
      run_prog(0, 1'b0);
      judge("R4 random", 1'b0, W);
    end

    // R5: partial byte at STOP, and STOP without data
    send_cmd(12'h100); send_byte(8'hA1);
    bit_count = 4'd3; @(negedge clk);
    send_stop(4'd3);
    expect_idle("R5 partial");
    send_cmd(12'h120);
    send_stop(4'd0);
    expect_idle("R5 empty");

    // R6: supply low at STOP
    send_cmd(12'h140); send_byte(8'hB2);
    low_vdd = 1'b1;
    send_stop(4'd0);
    low_vdd = 1'b0;
    expect_idle("R6 low supply");

    // R7: wp high only before the first data byte
    @(negedge clk); wp = 1'b1;
    send_cmd(12'h260);
    wp = 1'b0;
    send_byte(8'hC3); send_byte(8'hD4);
    send_stop(4'd0);
    run_prog(0, 1'b0);
    judge("R7 early wp", 1'b0, W);

    // R8: wp inside the collection window
    send_cmd(12'h280); send_byte(8'hE5);
    wp = 1'b1; @(negedge clk); wp = 1'b0;
    send_byte(8'hF6);
    send_stop(4'd0);
    expect_idle("R8 wp window");

    // R9: forced end mid-cycle
    send_cmd(12'h2A0); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    send_stop(4'd0);
    run_prog(10, 1'b0);
    judge("R9 forced end", 1'b1, 10);

    // R10: wp in the final busy cycle
    send_cmd(12'h2C7); send_byte(8'h77);
    send_stop(4'd0);
    run_prog(W, 1'b0);
    judge("R10 collision", 1'b1, W);

    // R11: traffic while busy is ignored
    send_cmd(12'h3E2); send_byte(8'h9A); send_byte(8'hBC);
    send_stop(4'd0);
    run_prog(0, 1'b1);
    judge("R11 busy traffic", 1'b0, W);
    expect_idle("R11 after write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule